// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block is the receive half of a UART-style serial port. It watches one serial line, finds the falling edge of a start bit, and times each bit with a sample tick from a programmable clock divider. Every bit period holds sixteen ticks. The three ticks at the middle of each bit are combined by majority vote. The voted bits are shifted into an 11-bit frame register, which holds a start bit, up to nine data bits and a stop bit. When the stop bit has been judged, the data moves into a read-only holding buffer and a full flag is raised. The software side then reads the buffer and acknowledges it with a single-cycle pulse.

Each frame carries eight or nine data bits. In nine-bit mode the top data bit appears on its own output, and the byte output keeps the lower eight. Parity checking is optional. When it is enabled, the last data bit of the frame is the parity bit, which can be even or odd. The line can be inverted before sampling. A loop mode takes the serial input from the local transmitter instead of the external pin. The block reports these status flags: buffer full, overrun, framing error, noise, parity error and idle line. It also shows a receiver-active level and drives two gated interrupt requests.

Top module: `serrx_core`

## Requirements
- R1: The divider gives one sample tick every `baud_div` clocks (a value of 0 stops the ticks), and a bit lasts 16 ticks. Frames are received correctly for any divisor from 1 upward.
- R2: In eight-bit mode (`nine_bit`=0), data bits arrive LSB first and land in `rx_data[7:0]`, and `rx_bit8` reads 0.
- R3: In nine-bit mode (`nine_bit`=1), the ninth received data bit (bit 8) appears on `rx_bit8`, and bits 0..7 appear on `rx_data`.
- R4: With `inv_pol`=1, the line is inverted before sampling, so the idle level is low, a start bit is high, and data bits read as the complement of the pin.
- R5: With `loop_en`=1, frames are taken from `tx_loop`, and `rx_pin` has no effect.
- R6: When a frame completes and the buffer is empty, the data is loaded and `full` rises. A one-cycle `ack` pulse clears `full`, `overrun`, `frame_err`, `noise`, `par_err` and `idle`.
- R7: With `par_en`=1, the last data bit (bit 7 in eight-bit mode, bit 8 in nine-bit mode) is parity. The XOR of all data bits must equal `par_odd` (0 for even, 1 for odd), or `par_err` is set with the frame. With `par_en`=0, `par_err` stays 0.
- R8: A stop bit whose vote is 0 sets `frame_err` with the frame, and the data is still delivered.
- R9: Each bit is the majority of samples 7, 8 and 9 of its 16. If those samples disagree for any bit of a frame, `noise` is set with that frame, and the data keeps the voted value.
- R10: A frame that completes while `full` is set raises `overrun`. The buffer, `rx_bit8` and the error flags keep the earlier frame.
- R11: A low start level whose mid-bit vote is high is a false start. No frame is produced, and the receiver goes back to looking for a start bit.
- R12: `idle` sets after the line has stayed high, with no frame in progress, for 160 ticks in eight-bit mode (176 in nine-bit mode). It stays clear after an acknowledge until the line has gone low and then become quiet again.
- R13: `irq_rx` is high exactly when `rie` is 1 and either `full` or `overrun` is set. `irq_idle` is high exactly when `ilie` is 1 and `idle` is set.
- R14: `active` is high from the detection of a start bit until the stop bit is judged or a false start is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 13 | Clocks per sample tick; 0 halts |
| rx_pin | input | 1 | External serial input |
| tx_loop | input | 1 | Local transmitter output, used in loop mode |
| loop_en | input | 1 | Select `tx_loop` as the line source |
| inv_pol | input | 1 | Invert the line before sampling |
| nine_bit | input | 1 | 1: nine data bits, 0: eight |
| par_en | input | 1 | Enable parity checking |
| par_odd | input | 1 | 1: odd parity, 0: even |
| rie | input | 1 | Enable for the receive interrupt |
| ilie | input | 1 | Enable for the idle interrupt |
| ack | input | 1 | Read-acknowledge pulse, clears the flags |
| rx_data | output | 8 | Received data bits 0..7 |
| rx_bit8 | output | 1 | Received data bit 8 |
| full | output | 1 | Buffer holds an unread frame |
| overrun | output | 1 | A frame was lost because the buffer was full |
| frame_err | output | 1 | Stop bit sampled low |
| noise | output | 1 | Mid-bit samples disagreed |
| par_err | output | 1 | Parity mismatch |
| idle | output | 1 | Idle line detected |
| active | output | 1 | Frame reception in progress |
| irq_rx | output | 1 | Receive interrupt request |
| irq_idle | output | 1 | Idle interrupt request |

## Verification
The bench builds the block with its defaults: a 13-bit divisor, 16 ticks per bit and a two-stage input synchroniser. It programs divisors 1 through 5, so a bit lasts 16 to 80 clocks, and dozens of randomly configured frames fit in a short run. It also reaches the 160-tick idle threshold, both right after reset and after a frame. A divisor of 4 lets a glitch one tick wide be placed so that it lands on exactly one of the three voting samples. This exercises the noise flag without disturbing the voted data.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int FRAME_W = 11;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [8:0] word;
        logic       frame_err;
        logic       noise;
        logic       par_err;
    } rx_frame_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || div == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && div > 1 && $stable(div)) |=> !tick);

endmodule

// File: rtl/rx_line_front.sv
module rx_line_front #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_pin,
    input  logic tx_loop,
    input  logic loop_en,
    input  logic inv_pol,
    output logic line
);
    logic            raw;
    logic [SYNC-1:0] chain;

    assign raw = (loop_en ? tx_loop : rx_pin) ^ inv_pol;

    generate
        for (genvar i = 0; i < SYNC; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b1;
                else if (i == 0)
                    chain[i] <= raw;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign line = chain[SYNC-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serrx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      nine_bit,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      active,
    output logic      done,
    output rx_frame_t res
);
    localparam int CW    = $clog2(OVS + 1);
    localparam int S_MID = OVS / 2;
    localparam int S_LO  = S_MID - 1;
    localparam int S_HI  = S_MID + 1;

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [CW-1:0]        n;
    logic [1:0]           early;
    logic [3:0]           bitn;
    logic [FRAME_W-1:0]   sh;
    logic                 nacc;
    logic                 vote, dis, last_bit, at_vote;
    logic [8:0]           word;

    assign n        = cnt + 1'b1;
    assign vote     = vote3(early[0], early[1], line);
    assign dis      = split3(early[0], early[1], line);
    assign at_vote  = tick && (state != ST_HUNT) && (n == CW'(S_HI));
    assign last_bit = (bitn == (nine_bit ? 4'd8 : 4'd7));
    assign word     = nine_bit ? sh[FRAME_W-1:2] : {1'b0, sh[FRAME_W-1:3]};
    assign active   = (state != ST_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            cnt   <= '0;
            early <= '0;
            bitn  <= '0;
            sh    <= '0;
            nacc  <= 1'b0;
            done  <= 1'b0;
            res   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == ST_HUNT) begin
                    if (!line) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                    end
                end else begin
                    cnt <= (n == CW'(OVS)) ? '0 : n;
                    if (n == CW'(S_LO)) early[0] <= line;
                    if (n == CW'(S_MID)) early[1] <= line;
                    if (n == CW'(S_HI)) begin
                        case (state)
                            ST_START: begin
                                if (vote) begin
                                    state <= ST_HUNT;
                                end else begin
                                    sh   <= {vote, sh[FRAME_W-1:1]};
                                    nacc <= dis;
                                end
                            end
                            ST_DATA: begin
                                sh   <= {vote, sh[FRAME_W-1:1]};
                                nacc <= nacc | dis;
                            end
                            ST_STOP: begin
                                done          <= 1'b1;
                                res.word      <= word;
                                res.frame_err <= !vote;
                                res.noise     <= nacc | dis;
                                res.par_err   <= par_en && ((^word) != par_odd);
                                state         <= ST_HUNT;
                            end
                            default: ;
                        endcase
                    end
                    if (n == CW'(OVS)) begin
                        if (state == ST_START) begin
                            state <= ST_DATA;
                            bitn  <= '0;
                        end else if (state == ST_DATA) begin
                            if (last_bit) state <= ST_STOP;
                            else bitn <= bitn + 1'b1;
                        end
                    end
                end
            end
        end
    end

    a_r11_false_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && at_vote && vote) |=> (!active && !done));

    a_r14_done_ends_frame: assert property (@(posedge clk) disable iff (rst)
        done |-> !active);

endmodule

// File: rtl/serrx_core.sv
module serrx_core
    import serrx_pkg::*;
#(
    parameter int DIV_W = 13,
    parameter int OVS   = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rx_pin,
    input  logic             tx_loop,
    input  logic             loop_en,
    input  logic             inv_pol,
    input  logic             nine_bit,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             rie,
    input  logic             ilie,
    input  logic             ack,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             full,
    output logic             overrun,
    output logic             frame_err,
    output logic             noise,
    output logic             par_err,
    output logic             idle,
    output logic             active,
    output logic             irq_rx,
    output logic             irq_idle
);
    localparam int IDLE8 = OVS * 10;
    localparam int IDLE9 = OVS * 11;
    localparam int IW    = $clog2(IDLE9 + 1);

    logic      tick, line, done;
    rx_frame_t res;
    logic [IW-1:0] quiet;
    logic [IW-1:0] quiet_lim;
    logic          idle_set;

    rx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
    );

    rx_line_front #(.SYNC(SYNC)) u_front (
        .clk(clk), .rst(rst), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_en(loop_en), .inv_pol(inv_pol), .line(line)
    );

    rx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .line(line),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .active(active), .done(done), .res(res)
    );

    assign quiet_lim = nine_bit ? IW'(IDLE9) : IW'(IDLE8);
    assign idle_set  = tick && !active && line && (quiet == quiet_lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || active || !line)
            quiet <= '0;
        else if (tick && quiet < quiet_lim)
            quiet <= quiet + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_bit8   <= 1'b0;
            full      <= 1'b0;
            overrun   <= 1'b0;
            frame_err <= 1'b0;
            noise     <= 1'b0;
            par_err   <= 1'b0;
            idle      <= 1'b0;
        end else begin
            if (ack) begin
                full      <= 1'b0;
                overrun   <= 1'b0;
                frame_err <= 1'b0;
                noise     <= 1'b0;
                par_err   <= 1'b0;
                idle      <= 1'b0;
            end
            if (idle_set) idle <= 1'b1;
            if (done) begin
                if (full && !ack) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data   <= res.word[7:0];
                    rx_bit8   <= res.word[8];
                    full      <= 1'b1;
                    frame_err <= res.frame_err;
                    noise     <= res.noise;
                    par_err   <= res.par_err;
                end
            end
        end
    end

    assign irq_rx   = rie && (full || overrun);
    assign irq_idle = ilie && idle;

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !done) |=> (!full && !overrun && !frame_err && !noise && !par_err));

    a_r10_overrun_holds: assert property (@(posedge clk) disable iff (rst)
        (done && full && !ack) |=> (overrun && $stable(rx_data) && $stable(rx_bit8)));

    a_r12_idle_when_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(idle) |-> !active);

endmodule

// File: tb/tb_serrx_core.sv
module tb_serrx_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] baud_div = 13'd4;
    logic        rx_pin = 1'b1, tx_loop = 1'b1, loop_en = 1'b0, inv_pol = 1'b0;
    logic        nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic        rie = 1'b1, ilie = 1'b1, ack = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_bit8, full, overrun, frame_err, noise, par_err, idle, active;
    logic        irq_rx, irq_idle;

    int checks = 0;
    int errors = 0;
    int B = 4;
    int unsigned cycles = 0;

    always #5 clk = ~clk;

    serrx_core dut (
        .clk(clk), .rst(rst), .baud_div(baud_div), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_en(loop_en), .inv_pol(inv_pol), .nine_bit(nine_bit), .par_en(par_en),
        .par_odd(par_odd), .rie(rie), .ilie(ilie), .ack(ack), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .full(full), .overrun(overrun), .frame_err(frame_err),
        .noise(noise), .par_err(par_err), .idle(idle), .active(active),
        .irq_rx(irq_rx), .irq_idle(irq_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [8:0] with_parity(input logic [8:0] raw, input int nb,
                                               input logic odd, input logic bad);
        logic [8:0] m;
        logic [8:0] w;
        m = (9'h1 << (nb - 1)) - 9'h1;
        w = raw & m;
        w[nb-1] = (^w) ^ odd ^ bad;
        return w;
    endfunction

    task automatic set_line(input logic v);
        if (loop_en) tx_loop = v ^ inv_pol;
        else rx_pin = v ^ inv_pol;
    endtask

    task automatic drive_bit(input logic v, input bit gl);
        set_line(v);
        if (gl) begin
            repeat (7*B + 3) @(negedge clk);
            set_line(!v);
            repeat (B) @(negedge clk);
            set_line(v);
            repeat (8*B - 3) @(negedge clk);
        end else begin
            repeat (16*B) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [8:0] bits, input int nb, input logic stop_v,
                              input int glitch_bit, input int gap);
        drive_bit(1'b0, 1'b0);
        chk("R14 active during frame", int'(active), 1);
        for (int i = 0; i < nb; i++) drive_bit(bits[i], glitch_bit == i);
        drive_bit(stop_v, 1'b0);
        set_line(1'b1);
        repeat (16*B*gap) @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg(input logic nb9, input logic pe, input logic po, input logic inv,
                       input logic lp, input logic ri, input logic il, input int b);
        nine_bit = nb9; par_en = pe; par_odd = po; rie = ri; ilie = il;
        inv_pol = inv; loop_en = lp; rx_pin = !inv; tx_loop = !inv;
        B = b; baud_div = 13'(b);
        repeat (32*B) @(negedge clk);
    endtask

    initial begin
        logic [8:0] w, a;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 reset full", int'(full), 0);
        chk("R10 reset overrun", int'(overrun), 0);
        chk("R12 reset idle", int'(idle), 0);
        chk("R14 reset active", int'(active), 0);
        chk("R13 reset irq_rx", int'(irq_rx), 0);

        repeat (700) @(negedge clk);
        chk("R12 idle after quiet line", int'(idle), 1);
        chk("R13 irq_idle follows idle", int'(irq_idle), 1);
        pulse_ack();
        repeat (700) @(negedge clk);
        chk("R12 idle stays clear without new activity", int'(idle), 0);

        for (int i = 0; i < 40; i++) begin
            logic n9, pe, po, inv, lp, ri, bp, bs;
            int nb;
            n9 = 1'($urandom % 2); pe = 1'($urandom % 2); po = 1'($urandom % 2);
            inv = 1'($urandom % 2); lp = 1'($urandom % 2); ri = 1'($urandom % 2);
            cfg(n9, pe, po, inv, lp, ri, 1'b1, 1 + int'($urandom % 5));
            nb = n9 ? 9 : 8;
            bp = pe && ($urandom % 4 == 0);
            bs = ($urandom % 5 == 0);
            w = 9'($urandom) & ((9'h1 << nb) - 9'h1);
            if (pe) w = with_parity(w, nb, po, bp);
            send_frame(w, nb, !bs, -1, 3);
            chk("R1 R2 R4 R5 data byte", int'(rx_data), int'(w[7:0]));
            chk("R3 ninth bit", int'(rx_bit8), int'(n9 ? w[8] : 1'b0));
            chk("R6 full after frame", int'(full), 1);
            chk("R8 frame error", int'(frame_err), int'(bs));
            chk("R7 parity error", int'(par_err), int'(bp));
            chk("R9 clean frame no noise", int'(noise), 0);
            chk("R10 no overrun", int'(overrun), 0);
            chk("R13 irq_rx gating", int'(irq_rx), int'(ri));
            chk("R14 inactive after frame", int'(active), 0);
            pulse_ack();
            chk("R6 ack clears full", int'(full), 0);
            chk("R13 irq_rx after ack", int'(irq_rx), 0);
        end

        cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4);
        a = 9'h0A5;
        send_frame(a, 8, 1'b1, -1, 2);
        send_frame(9'h03C, 8, 1'b1, -1, 2);
        chk("R10 overrun set", int'(overrun), 1);
        chk("R10 old data kept", int'(rx_data), 8'hA5);
        chk("R10 full still set", int'(full), 1);
        chk("R13 irq_rx on overrun", int'(irq_rx), 1);
        pulse_ack();
        chk("R6 ack clears overrun", int'(overrun), 0);

        send_frame(9'h0C3, 8, 1'b1, 2, 2);
        chk("R9 noise flagged", int'(noise), 1);
        chk("R9 voted data intact", int'(rx_data), 8'hC3);
        pulse_ack();
        chk("R6 ack clears noise", int'(noise), 0);

        set_line(1'b0);
        repeat (4*B) @(negedge clk);
        set_line(1'b1);
        repeat (48*B) @(negedge clk);
        chk("R11 false start gives no frame", int'(full), 0);
        chk("R11 receiver back to hunting", int'(active), 0);

        send_frame(9'h05A, 8, 1'b1, -1, 0);
        pulse_ack();
        repeat (80*B) @(negedge clk);
        chk("R12 idle not before threshold", int'(idle), 0);
        repeat (192*B) @(negedge clk);
        chk("R12 idle after a frame", int'(idle), 1);
        chk("R13 irq_idle", int'(irq_idle), 1);
        ilie = 1'b0;
        @(negedge clk);
        chk("R13 irq_idle masked", int'(irq_idle), 0);
        pulse_ack();

        cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2);
        rx_pin = 1'b0;
        send_frame(9'h081, 8, 1'b1, -1, 2);
        chk("R5 loop source data", int'(rx_data), 8'h81);
        chk("R5 loop frame clean", int'(frame_err), 0);
        rx_pin = 1'b1;
        pulse_ack();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule